// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block decides which clock domains of a small microcontroller keep running while the core sleeps. Software first writes a control byte. That byte holds a sleep-enable bit and a 3-bit mode code. The core then raises a one-cycle sleep request. If sleeping is enabled and the mode code is a valid one, the controller drops the clock enables that the chosen mode switches off. It keeps them off until an enabled interrupt arrives or a reset is requested.

An interrupt wake has two phases. Modes that stop the main oscillator first wait a start-up delay, whose length is a parameter. Every mode then holds the CPU for four more cycles with all the other domains running. After that the CPU clock returns and a one-cycle pulse tells the core that it may service the interrupt. A reset request during any part of sleep or wake skips this sequence. All clocks come back on the next cycle, and a one-cycle pulse flags a restart from the reset vector.

The control byte is never cleared on a wake. The controller's own clock runs at all times, and it counts the start-up delay in cycles of that clock.

Top module: `slp_power_ctl`

## Requirements
- R1: While reset is held and in the first cycle after it, reg_rdata is 0x00, every clock enable is 1, and busy, irq_go and restart_vec are 0.
- R2: A write stores bit 0 as sleep enable and bits 3..1 as the mode code. reg_rdata returns those four bits in the same positions, and bits 7..4 always read 0 whatever was written to them.
- R3: A sleep request made while sleep enable is 0 is ignored. All clock enables stay 1 and busy stays 0.
- R4: A sleep request with mode code 011, 100, 101, 110 or 111 is a no-op, even when sleep enable is 1. No clock enable drops and busy stays 0.
- R5: Mode 000 (idle). From the cycle after an accepted request, ce_cpu and ce_flash are 0, ce_io, ce_adc and ce_tmr are 1, and busy is 1.
- R6: Mode 001 (ADC quiet). ce_cpu, ce_flash and ce_io are 0, ce_adc and ce_tmr are 1, and busy is 1.
- R7: Mode 010 (deep power-down). Only ce_tmr stays 1, and busy is 1.
- R8: In idle, irq_wake sampled high starts a halt of exactly 4 cycles. During the halt busy is 1, ce_cpu is 0 and the other enables are 1. In the following cycle irq_go is 1 for that one cycle, ce_cpu is 1 and busy is 0.
- R9: In modes 001 and 010, irq_wake is first followed by exactly STARTUP_CYC cycles in which the sleep gating is unchanged and busy is 1. The 4-cycle halt and the irq_go pulse of R8 then follow.
- R10: ext_rst sampled high while busy ends the sequence in the next cycle. All enables are then 1, busy is 0 and restart_vec is 1 for one cycle, and no irq_go follows.
- R11: The stored control byte is unchanged by sleep entry, interrupt wake and reset wake.
- R12: While not busy, irq_wake and ext_rst have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst | input | 1 | Synchronous active-high block reset |
| reg_we | input | 1 | Control byte write strobe |
| reg_wdata | input | 8 | Control byte write data |
| reg_rdata | output | 8 | Control byte read value |
| sleep_req | input | 1 | One-cycle sleep request from the core |
| irq_wake | input | 1 | An enabled interrupt is pending |
| ext_rst | input | 1 | Reset request that wakes to the reset vector |
| ce_cpu | output | 1 | CPU clock enable |
| ce_flash | output | 1 | Program memory clock enable |
| ce_io | output | 1 | Peripheral I/O clock enable |
| ce_adc | output | 1 | Converter clock enable |
| ce_tmr | output | 1 | Asynchronous timer / wake logic clock enable |
| busy | output | 1 | High from sleep entry until the halt ends |
| irq_go | output | 1 | One-cycle pulse: interrupt may be serviced |
| restart_vec | output | 1 | One-cycle pulse: restart from reset vector |

## Verification
A wrong sleep state or latched mode shows up one cycle after the request as the wrong pattern on the five enables. The bench compares that pattern in every cycle of sleep for all eight codes, with the enable bit both set and clear. An off-by-one in the start-up or halt count moves irq_go and the return of ce_cpu by a cycle. Every cycle of the wake is therefore compared against a count derived from STARTUP_CYC. A bad reset-wake path shows as a late or missing restart_vec, or a stray irq_go in the few cycles after the reset request. The bench probes this path from sleep, from start-up and from the halt.

// File: rtl/slp_pkg.sv
package slp_pkg;

    localparam int CTRL_W   = 8;
    localparam int HALT_CYC = 4;

    typedef logic [2:0] mode_t;

    localparam mode_t MODE_IDLE  = 3'b000;
    localparam mode_t MODE_ADCQ  = 3'b001;
    localparam mode_t MODE_PDOWN = 3'b010;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_START = 2'd2,
        ST_HALT  = 2'd3
    } state_e;

    typedef struct packed {
        logic cpu;
        logic flash;
        logic io;
        logic adc;
        logic tmr;
    } clk_en_t;

    localparam clk_en_t CE_ALL_ON = '{cpu: 1'b1, flash: 1'b1, io: 1'b1, adc: 1'b1, tmr: 1'b1};
    localparam clk_en_t CE_HALT   = '{cpu: 1'b0, flash: 1'b1, io: 1'b1, adc: 1'b1, tmr: 1'b1};

    function automatic logic mode_valid(input mode_t m);
        return (m == MODE_IDLE) || (m == MODE_ADCQ) || (m == MODE_PDOWN);
    endfunction

    function automatic logic mode_stops_osc(input mode_t m);
        return (m == MODE_ADCQ) || (m == MODE_PDOWN);
    endfunction

    function automatic clk_en_t sleep_gate(input mode_t m);
        clk_en_t g;
        g = CE_ALL_ON;
        case (m)
            MODE_IDLE: begin
                g.cpu   = 1'b0;
                g.flash = 1'b0;
            end
            MODE_ADCQ: begin
                g.cpu   = 1'b0;
                g.flash = 1'b0;
                g.io    = 1'b0;
            end
            MODE_PDOWN: begin
                g.cpu   = 1'b0;
                g.flash = 1'b0;
                g.io    = 1'b0;
                g.adc   = 1'b0;
            end
            default: g = CE_ALL_ON;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/slp_ctrl_reg.sv
module slp_ctrl_reg
    import slp_pkg::*;
#(
    parameter int W = CTRL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output mode_t        mode,
    output logic         enable
);

    localparam logic [W-1:0] WR_MASK = W'(4'hF);

    logic [W-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (we) begin
            ctrl_q <= wdata & WR_MASK;
        end
    end

    assign rdata  = ctrl_q;
    assign enable = ctrl_q[0];
    assign mode   = ctrl_q[3:1];

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(rdata)); // R11

endmodule

// File: rtl/slp_wake_seq.sv
module slp_wake_seq
    import slp_pkg::*;
#(
    parameter int STARTUP_CYC = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   sleep_req,
    input  logic   irq_wake,
    input  logic   ext_rst,
    input  logic   enable,
    input  mode_t  mode,
    output state_e state,
    output mode_t  slp_mode,
    output logic   irq_go,
    output logic   restart
);

    localparam int CMAX = (STARTUP_CYC > HALT_CYC) ? STARTUP_CYC : HALT_CYC;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] START_LAST = CW'(STARTUP_CYC - 1);
    localparam logic [CW-1:0] HALT_LAST  = CW'(HALT_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_RUN;
            slp_mode <= MODE_IDLE;
            cnt      <= '0;
            irq_go   <= 1'b0;
            restart  <= 1'b0;
        end else begin
            irq_go  <= 1'b0;
            restart <= 1'b0;
            if (state != ST_RUN && ext_rst) begin
                state   <= ST_RUN;
                cnt     <= '0;
                restart <= 1'b1;
            end else begin
                case (state)
                    ST_RUN: begin
                        if (sleep_req && enable && mode_valid(mode)) begin
                            state    <= ST_SLEEP;
                            slp_mode <= mode;
                        end
                    end
                    ST_SLEEP: begin
                        if (irq_wake) begin
                            cnt   <= '0;
                            state <= mode_stops_osc(slp_mode) ? ST_START : ST_HALT;
                        end
                    end
                    ST_START: begin
                        if (cnt == START_LAST) begin
                            cnt   <= '0;
                            state <= ST_HALT;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_HALT: begin
                        if (cnt == HALT_LAST) begin
                            cnt    <= '0;
                            state  <= ST_RUN;
                            irq_go <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_RUN;
                endcase
            end
        end
    end

    AST_NO_SLEEP_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !enable) |=> state == ST_RUN); // R3

    AST_RESERVED_NOP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !mode_valid(mode)) |=> state == ST_RUN); // R4

    AST_GO_FROM_HALT: assert property (@(posedge clk) disable iff (rst)
        irq_go |-> $past(state) == ST_HALT); // R8

    AST_RST_WAKE: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RUN && ext_rst) |=> (state == ST_RUN && restart && !irq_go)); // R10

endmodule

// File: rtl/slp_clk_gate.sv
module slp_clk_gate
    import slp_pkg::*;
(
    input  state_e  state,
    input  mode_t   slp_mode,
    output clk_en_t ce
);

    always_comb begin
        case (state)
            ST_SLEEP, ST_START: ce = sleep_gate(slp_mode);
            ST_HALT:            ce = CE_HALT;
            default:            ce = CE_ALL_ON;
        endcase
    end

endmodule

// File: rtl/slp_power_ctl.sv
module slp_power_ctl
    import slp_pkg::*;
#(
    parameter int STARTUP_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic              sleep_req,
    input  logic              irq_wake,
    input  logic              ext_rst,
    output logic              ce_cpu,
    output logic              ce_flash,
    output logic              ce_io,
    output logic              ce_adc,
    output logic              ce_tmr,
    output logic              busy,
    output logic              irq_go,
    output logic              restart_vec
);

    mode_t   cur_mode;
    logic    cur_en;
    state_e  state;
    mode_t   slp_mode;
    clk_en_t ce;

    slp_ctrl_reg #(.W(CTRL_W)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .mode   (cur_mode),
        .enable (cur_en)
    );

    slp_wake_seq #(.STARTUP_CYC(STARTUP_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_req),
        .irq_wake  (irq_wake),
        .ext_rst   (ext_rst),
        .enable    (cur_en),
        .mode      (cur_mode),
        .state     (state),
        .slp_mode  (slp_mode),
        .irq_go    (irq_go),
        .restart   (restart_vec)
    );

    slp_clk_gate u_gate (
        .state    (state),
        .slp_mode (slp_mode),
        .ce       (ce)
    );

    assign ce_cpu   = ce.cpu;
    assign ce_flash = ce.flash;
    assign ce_io    = ce.io;
    assign ce_adc   = ce.adc;
    assign ce_tmr   = ce.tmr;
    assign busy     = (state != ST_RUN);

    AST_CPU_OFF_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !ce_cpu); // R5

    AST_GO_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq_go |=> !irq_go); // R8

    AST_GO_CPU_ON: assert property (@(posedge clk) disable iff (rst)
        irq_go |-> (ce_cpu && !busy)); // R8

    AST_IDLE_RUN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!busy && !sleep_req) |=> (!busy && !irq_go && !restart_vec)); // R12

endmodule

// File: tb/sim_slp_power_ctl.sv
module sim_slp_power_ctl;

    localparam int SU = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sleep_req = 1'b0;
    logic       irq_wake = 1'b0;
    logic       ext_rst = 1'b0;
    logic       ce_cpu, ce_flash, ce_io, ce_adc, ce_tmr;
    logic       busy, irq_go, restart_vec;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    slp_power_ctl #(.STARTUP_CYC(SU)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sleep_req(sleep_req), .irq_wake(irq_wake),
        .ext_rst(ext_rst), .ce_cpu(ce_cpu), .ce_flash(ce_flash), .ce_io(ce_io),
        .ce_adc(ce_adc), .ce_tmr(ce_tmr), .busy(busy), .irq_go(irq_go),
        .restart_vec(restart_vec)
    );

    wire [4:0] ce = {ce_cpu, ce_flash, ce_io, ce_adc, ce_tmr};

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 act=%0d exp<=20000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // {cpu,flash,io,adc,tmr} while sleeping, per R5/R6/R7
    function automatic logic [4:0] sleep_exp(input logic [2:0] m);
        case (m)
            3'd0:    return 5'b00111;
            3'd1:    return 5'b00011;
            3'd2:    return 5'b00001;
            default: return 5'b11111;
        endcase
    endfunction

    function automatic string mode_tag(input logic [2:0] m);
        if (m == 3'd0) return "R5";
        if (m == 3'd1) return "R6";
        return "R7";
    endfunction

    task automatic write_reg(input logic [7:0] v);
        reg_we = 1'b1;
        reg_wdata = v;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic enter(input logic [2:0] m, input logic en);
        write_reg({4'b1010, m, en});
        chk("R2 rdata", {24'd0, reg_rdata}, {24'd0, 4'b0000, m, en});
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        if (en && m <= 3'd2) begin
            chk({mode_tag(m), " gate"}, {27'd0, ce}, {27'd0, sleep_exp(m)});
            chk({mode_tag(m), " busy"}, {31'd0, busy}, 32'd1);
            tick();
            chk({mode_tag(m), " gate hold"}, {27'd0, ce}, {27'd0, sleep_exp(m)});
        end else if (!en) begin
            chk("R3 gate", {27'd0, ce}, 32'h1f);
            chk("R3 busy", {31'd0, busy}, 32'd0);
        end else begin
            chk("R4 gate", {27'd0, ce}, 32'h1f);
            chk("R4 busy", {31'd0, busy}, 32'd0);
        end
    endtask

    task automatic wake_irq(input logic [2:0] m, input logic [7:0] stored);
        irq_wake = 1'b1;
        tick();
        irq_wake = 1'b0;
        if (m != 3'd0) begin
            for (int i = 0; i < SU; i++) begin
                chk("R9 startup gate", {27'd0, ce}, {27'd0, sleep_exp(m)});
                chk("R9 startup busy", {30'd0, busy, irq_go}, 32'd2);
                tick();
            end
        end
        for (int i = 0; i < 4; i++) begin
            chk("R8 halt gate", {27'd0, ce}, 32'h0f);
            chk("R8 halt busy", {30'd0, busy, irq_go}, 32'd2);
            tick();
        end
        chk("R8 go", {30'd0, busy, irq_go}, 32'd1);
        chk("R8 ce after", {27'd0, ce}, 32'h1f);
        tick();
        chk("R8 go one cycle", {31'd0, irq_go}, 32'd0);
        chk("R11 reg kept", {24'd0, reg_rdata}, {24'd0, stored});
    endtask

    task automatic wake_rst(input logic [2:0] m, input int phase);
        enter(m, 1'b1);
        if (phase >= 1) begin
            irq_wake = 1'b1;
            tick();
            irq_wake = 1'b0;
            if (phase == 2 && m != 3'd0) begin
                repeat (SU) tick();
            end
            if (phase == 2) tick();
        end
        ext_rst = 1'b1;
        tick();
        ext_rst = 1'b0;
        chk("R10 ce", {27'd0, ce}, 32'h1f);
        chk("R10 flags", {29'd0, busy, irq_go, restart_vec}, 32'd1);
        for (int i = 0; i < 8; i++) begin
            tick();
            chk("R10 quiet", {29'd0, busy, irq_go, restart_vec}, 32'd0);
        end
        chk("R11 reg after reset wake", {24'd0, reg_rdata}, {24'd0, 4'b0000, m, 1'b1});
    endtask

    initial begin
        tick();
        tick();
        chk("R1 rdata in reset", {24'd0, reg_rdata}, 32'd0);
        chk("R1 ce in reset", {27'd0, ce}, 32'h1f);
        chk("R1 flags in reset", {29'd0, busy, irq_go, restart_vec}, 32'd0);
        rst = 1'b0;
        tick();
        chk("R1 rdata", {24'd0, reg_rdata}, 32'd0);
        chk("R1 ce", {27'd0, ce}, 32'h1f);
        chk("R1 flags", {29'd0, busy, irq_go, restart_vec}, 32'd0);

        for (int m = 0; m < 8; m++) begin
            for (int en = 0; en < 2; en++) begin
                enter(3'(m), 1'(en));
                if (en == 1 && m <= 2) begin
                    wake_irq(3'(m), {4'b0000, 3'(m), 1'b1});
                end
            end
        end

        for (int m = 0; m < 3; m++) begin
            for (int ph = 0; ph < 3; ph++) begin
                wake_rst(3'(m), ph);
            end
        end

        write_reg(8'h05);
        irq_wake = 1'b1;
        ext_rst = 1'b1;
        tick();
        irq_wake = 1'b0;
        ext_rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk("R12 ce", {27'd0, ce}, 32'h1f);
            chk("R12 flags", {29'd0, busy, irq_go, restart_vec}, 32'd0);
            tick();
        end
        chk("R12 reg", {24'd0, reg_rdata}, 32'h05);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule